// File: doc/BRIEF.md
# MDIO Station-Management Master

This block is the management-side engine that a MAC or a small controller uses to read and write the registers of an attached Ethernet PHY. For each accepted request it generates the management clock and runs one complete register-access frame on a shared, open-drain style data line. The line is presented as a driven value, a drive enable and the sensed input, so the pad and its pull-up resistor stay outside.

A request is a one-cycle start strobe together with a direction select, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block latches them, raises `busy`, shifts the frame out and, on reads, lets go of the line at the turnaround so the PHY can answer. The returned 16 bits are assembled in `rd_data`. A one-cycle `done` marks the end. The 32-bit leading run of ones can be left out per request, for PHYs that accept short frames. The clock divider takes a requested half-period in system cycles and raises it whenever it would break the timing floor of the management clock.

Top module: `mdio_master`

## Requirements
- R1: With `no_preamble` low, a frame has exactly 64 MDC rising edges; the line reads 1 at the first 32 of them and then the start pattern 0,1.
- R2: Bit pair 34..35 carries the opcode, 1,0 for a read (`is_read`=1) and 0,1 for a write. Bits 36..40 carry `phy_addr` and bits 41..45 carry `reg_addr`, each MSB first.
- R3: On a write, `mdio_oe` stays high for the whole frame, bits 46..47 carry 1,0, and bits 48..63 carry `wr_data` MSB first.
- R4: On a read, `mdio_oe` is high for bits 0..45 and low from bit 46 to the end. The line values at the rising edges of bits 48..63 land in `rd_data`, first bit as the MSB.
- R5: With `no_preamble` high, the frame begins directly at the start pattern and has 32 rising edges, carrying bits 32..63 as above.
- R6: `mdio_o` and `mdio_oe` change only in the same system cycle that MDC goes low. They never change while MDC is high.
- R7: Each MDC high and low level lasts max(`DIV_HALF`, ceil(200 ns / `CLK_PERIOD_NS`)) system cycles. This gives at least 160 ns per level and at least 400 ns per period.
- R8: After reset and whenever `busy` is low, `mdc` is low and `mdio_oe` is low. Reset also clears `busy`, `done` and `rd_data`.
- R9: A `start` that arrives while `busy` is high is ignored. The running frame is unchanged and no extra frame follows.
- R10: `done` is high for exactly one system cycle per frame, in the cycle `busy` goes low after the last bit's rising edge.
- R11: `rd_data` keeps its value while idle and through write frames. It changes only during a read frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request strobe, taken only when idle |
| is_read | input | 1 | 1 = register read, 0 = register write |
| no_preamble | input | 1 | 1 = leave out the 32-bit run of ones |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register number |
| wr_data | input | 16 | Data for a write |
| rd_data | output | 16 | Data returned by the last read |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven onto the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| mdio_i | input | 1 | Sensed data-line value |

## Verification
On every cycle, the assertions check that the line stays still while MDC is high, that each MDC level meets the 160 ns floor, that the line is released and MDC parked low when idle, the single-cycle `done`, and that `rd_data` is frozen between frames. The bit-by-bit frame contents, the exact point of release at the turnaround, the capture order of read data, the short-frame mode and the rejection of a mid-frame start can only be shown by the bench's frame scenarios. In those scenarios a PHY model answers reads, and every sampled bit is compared against a frame rebuilt from the request fields.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;

  localparam int FRAME_LEN  = 64;
  localparam int LEAD_LEN   = 32;
  localparam int TURN_POS   = 46;
  localparam int PAYLD_POS  = 48;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int POS_W      = $clog2(FRAME_LEN);

  typedef enum logic [1:0] {
    OPC_WRITE = 2'b01,
    OPC_READ  = 2'b10
  } mdio_opc_e;

  // Half-period in system cycles: the request, raised so that one full
  // MDC period spans at least 400 ns (which also covers 160 ns per level).
  function automatic int level_cycles(input int clk_ns, input int want);
    int floor_c;
    floor_c = (200 + clk_ns - 1) / clk_ns;
    return (want > floor_c) ? want : floor_c;
  endfunction

  function automatic logic [FRAME_LEN-1:0] make_frame(
    input logic              rd,
    input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] rga,
    input logic [DATA_W-1:0] wd
  );
    mdio_opc_e opc;
    opc = rd ? OPC_READ : OPC_WRITE;
    return {{LEAD_LEN{1'b1}}, 2'b01, opc, phy, rga, 2'b10, wd};
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
module mdio_clkgen #(
  parameter int HALF = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap     = (cnt == CW'(HALF - 1));
  assign rise_stb = run && wrap && !mdc;
  assign fall_stb = run && wrap &&  mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/mdio_framer.sv
`timescale 1ns/1ps
module mdio_framer
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              is_read,
  input  logic              no_preamble,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rd_data
);
  logic [FRAME_LEN-1:0] shreg;
  logic [FRAME_LEN-1:0] fresh;
  logic [POS_W-1:0]     pos;
  logic [POS_W-1:0]     pos_nx;
  logic                 rd_q;
  logic                 last;

  assign fresh  = make_frame(is_read, phy_addr, reg_addr, wr_data);
  assign pos_nx = pos + POS_W'(1);
  assign last   = (pos == POS_W'(FRAME_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      pos     <= '0;
      rd_q    <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          rd_q    <= is_read;
          mdio_oe <= 1'b1;
          if (no_preamble) begin
            shreg  <= {fresh[LEAD_LEN-1:0], {LEAD_LEN{1'b0}}};
            pos    <= POS_W'(LEAD_LEN);
            mdio_o <= fresh[LEAD_LEN-1];
          end else begin
            shreg  <= fresh;
            pos    <= '0;
            mdio_o <= fresh[FRAME_LEN-1];
          end
        end
      end else begin
        if (rise_stb && rd_q && (pos >= POS_W'(PAYLD_POS)))
          rd_data <= {rd_data[DATA_W-2:0], mdio_i};
        if (fall_stb) begin
          if (last) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b1;
          end else begin
            pos     <= pos_nx;
            shreg   <= {shreg[FRAME_LEN-2:0], 1'b0};
            mdio_o  <= shreg[FRAME_LEN-2];
            mdio_oe <= !(rd_q && (pos_nx >= POS_W'(TURN_POS)));
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
  import mdio_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 5,
  parameter int DIV_HALF      = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        is_read,
  input  logic        no_preamble,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic        busy,
  output logic        done,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int HALF = level_cycles(CLK_PERIOD_NS, DIV_HALF);

  logic rise_stb;
  logic fall_stb;

  mdio_clkgen #(.HALF(HALF)) u_clkgen (
    .clk      (clk),
    .rst      (rst),
    .run      (busy),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_framer u_framer (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .is_read     (is_read),
    .no_preamble (no_preamble),
    .phy_addr    (phy_addr),
    .reg_addr    (reg_addr),
    .wr_data     (wr_data),
    .rise_stb    (rise_stb),
    .fall_stb    (fall_stb),
    .mdio_i      (mdio_i),
    .busy        (busy),
    .done        (done),
    .mdio_o      (mdio_o),
    .mdio_oe     (mdio_oe),
    .rd_data     (rd_data)
  );
endmodule

// File: rtl/mdio_master_chk.sv
`timescale 1ns/1ps
module mdio_master_chk #(
  parameter int CLK_PERIOD_NS = 5
) (
  input logic        clk,
  input logic        rst,
  input logic        mdc,
  input logic        busy,
  input logic        done,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [15:0] rd_data
);
  localparam int MIN_LVL = (160 + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;

  logic        mdc_q;
  logic [15:0] lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_q <= 1'b0;
      lvl   <= '0;
    end else begin
      mdc_q <= mdc;
      if (mdc != mdc_q)     lvl <= 16'd1;
      else if (lvl != '1)   lvl <= lvl + 16'd1;
    end
  end

  // R6
  line_still_high_chk: assert property (@(posedge clk) disable iff (rst)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R7
  mdc_level_len_chk: assert property (@(posedge clk) disable iff (rst)
    (mdc != mdc_q) |-> (int'(lvl) >= MIN_LVL));

  // R8
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_oe));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  done_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(rd_data));
endmodule

bind mdio_master mdio_master_chk #(.CLK_PERIOD_NS(CLK_PERIOD_NS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .mdc     (mdc),
  .busy    (busy),
  .done    (done),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe),
  .rd_data (rd_data)
);

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
  localparam int CLK_NS = 5;
  localparam int LVL    = (200 + CLK_NS - 1) / CLK_NS;
  localparam int LIMIT  = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        is_read = 1'b0;
  logic        no_preamble = 1'b0;
  logic [4:0]  phy_addr = '0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        busy, done, mdc, mdio_o, mdio_oe;
  logic        mdio_i;

  logic phy_en = 1'b0;
  logic phy_val = 1'b1;
  assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

  always #2.5 clk = ~clk;

  mdio_master #(.CLK_PERIOD_NS(CLK_NS), .DIV_HALF(1)) i_mdio_master (
    .clk(clk), .rst(rst), .start(start), .is_read(is_read),
    .no_preamble(no_preamble), .phy_addr(phy_addr), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .busy(busy), .done(done),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int donecnt = 0;
  int rcnt = 0;
  int off = 0;
  int nxb = 0;
  logic        cur_rd = 1'b0;
  logic [15:0] cur_pv = '0;
  logic        line_log [64];
  logic        oe_log   [64];
  logic [15:0] exp_rd = '0;

  int run_len = 0;
  int min_hi = 1000000;
  int min_lo = 1000000;
  int last_hi = 0;
  int min_per = 1000000;
  logic mdc_s = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (done) donecnt++;
    if (mdc == mdc_s) run_len++;
    else begin
      if (mdc_s) begin
        if (run_len < min_hi) min_hi = run_len;
        last_hi = run_len;
      end else if (busy) begin
        if (run_len < min_lo) min_lo = run_len;
        if (last_hi > 0 && last_hi + run_len < min_per) min_per = last_hi + run_len;
      end
      run_len = 1;
      mdc_s = mdc;
    end
  end

  // PHY model: samples at MDC rise, drives its answer after MDC falls.
  always @(posedge mdc) begin
    if (off + rcnt < 64) begin
      line_log[off + rcnt] = mdio_i;
      oe_log[off + rcnt]   = mdio_oe;
    end
    rcnt++;
  end

  always @(negedge mdc) begin
    nxb = off + rcnt;
    if (cur_rd && nxb >= 47 && nxb <= 63) begin
      phy_en  = 1'b1;
      phy_val = (nxb == 47) ? 1'b0 : cur_pv[63 - nxb];
    end else begin
      phy_en  = 1'b0;
      phy_val = 1'b1;
    end
  end

  task automatic run_frame(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] wd, input logic [15:0] pv,
                           input logic nop, input logic poke);
    logic [63:0] expf;
    bit ok_line, ok_oe;
    expf = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), pa, ra, 2'b10, (rd ? pv : wd)};
    @(negedge clk);
    is_read = rd; phy_addr = pa; reg_addr = ra; wr_data = wd; no_preamble = nop;
    cur_rd = rd; cur_pv = pv; off = nop ? 32 : 0; rcnt = 0; donecnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10", "busy after start", 64'(busy), 64'd1);
    if (poke) begin
      repeat (700) @(negedge clk);
      is_read = ~rd; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~wd; no_preamble = ~nop;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy && cyc < LIMIT) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(rcnt == 64 - off, nop ? "R5" : "R1", "MDC rising edges",
        64'(rcnt), 64'(64 - off));
    ok_line = 1'b1; ok_oe = 1'b1;
    for (int k = off; k < 64; k++) begin
      if (line_log[k] !== expf[63 - k]) ok_line = 1'b0;
      if (oe_log[k] !== (rd ? (k < 46) : 1'b1)) ok_oe = 1'b0;
    end
    chk(ok_line, rd ? "R2/R4" : "R2/R3", "frame bits", expf, expf);
    if (!ok_line)
      for (int k = off; k < 64; k++)
        if (line_log[k] !== expf[63 - k])
          $display("  bit %0d line %b want %b", k, line_log[k], expf[63 - k]);
    chk(ok_oe, rd ? "R4" : "R3", "drive enable pattern", 64'(ok_oe), 64'd1);
    chk(donecnt == 1, "R10", "done pulses", 64'(donecnt), 64'd1);
    if (rd) exp_rd = pv;
    chk(rd_data == exp_rd, rd ? "R4" : "R11", "rd_data", 64'(rd_data), 64'(exp_rd));
    chk(!busy && !mdc && !mdio_oe, "R8", "idle after frame",
        {61'd0, busy, mdc, mdio_oe}, 64'd0);
    if (poke) chk(!busy && rcnt == 64 - off, "R9", "late start ignored",
                  64'(busy), 64'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rd_data == 16'h0, "R8", "reset rd_data", 64'(rd_data), 64'd0);
    chk(!busy && !done && !mdc && !mdio_oe, "R8", "reset controls",
        {60'd0, busy, done, mdc, mdio_oe}, 64'd0);

    // walking-one address and data sweep, writes then reads
    for (int i = 0; i < 5; i++)
      run_frame(1'b0, 5'(1 << i), 5'(~(1 << i)), 16'(16'h8001 >> i) ^ 16'h5A00,
                16'h0, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++)
      run_frame(1'b1, 5'(~(1 << i)), 5'(1 << i), 16'hFFFF,
                16'(16'h1 << (3 * i)) ^ 16'hC3A5, 1'b0, 1'b0);
    // R11: write after read leaves rd_data alone
    run_frame(1'b0, 5'd31, 5'd0, 16'h0000, 16'h0, 1'b0, 1'b0);
    // R5: short frames
    run_frame(1'b1, 5'd0, 5'd31, 16'h0, 16'hFFFF, 1'b1, 1'b0);
    run_frame(1'b0, 5'd21, 5'd10, 16'hAAAA, 16'h0, 1'b1, 1'b0);
    run_frame(1'b1, 5'd10, 5'd21, 16'h0, 16'h0001, 1'b1, 1'b0);
    // R9: start during a frame
    run_frame(1'b0, 5'd3, 5'd12, 16'h1234, 16'h0, 1'b0, 1'b1);
    run_frame(1'b1, 5'd12, 5'd3, 16'h0, 16'h8000, 1'b0, 1'b1);

    // R7: level and period lengths
    chk(min_hi >= LVL, "R7", "min MDC high", 64'(min_hi), 64'(LVL));
    chk(min_lo >= LVL, "R7", "min MDC low", 64'(min_lo), 64'(LVL));
    chk(min_per >= 400 / CLK_NS, "R7", "min MDC period", 64'(min_per), 64'(400 / CLK_NS));

    if (cyc >= LIMIT) chk(1'b0, "R10", "watchdog expired", 64'(cyc), 64'(LIMIT));
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_NS * (LIMIT + 5000));
    tests++; fails++;
    $display("FAIL R10 watchdog: actual %0d expected below %0d", cyc, LIMIT);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule